// File: doc/BRIEF.md
# Three-Wire Serial Register Slave for a Panel Driver

This block lets a host reach the configuration bytes of a display driver chip over a three-wire serial link. The link has an active-low chip select, a serial clock and one shared data line. Inside the chip that line is split into an input, an output value and an output enable. The host changes data while the clock is low, and the slave samples on each rising clock edge. All three link inputs pass through a synchronizer onto the block's own clock, so the serial clock must stay well below that clock rate.

A frame starts with a six-bit address and a direction bit, both sent most significant bit first. A write frame then carries one pad bit and a data byte. A read frame then has one clock in which nobody drives the line, followed by eight bits that the slave drives back. Four byte registers are mapped: scratch, identity, resolution and power/ownership. The ownership bit chooses where the panel's resolution code and standby state come from: the register file or two strap inputs.

Top module: `tw_reg_slave`

## Requirements
- R1: A frame is six address bits (MSB first), one direction bit (0 = write), one ignored pad bit and eight data bits (MSB first). The register changes only when the sixteenth rising clock edge of a write frame is sampled.
- R2: For a read frame (direction bit 1), `sdaOe` stays low through the eighth clock. After the falling edge that ends the eighth clock, `sdaOe` rises and `sdaOut` gives the register byte MSB first, one bit per falling edge. `sdaOe` drops after the sixteenth falling edge.
- R3: Address 0x00 is a scratch byte that can be written and read. It resets to 0x00, and writing 0x55 reads back 0x55.
- R4: Address 0x01 reads as {CHIP_ID, VERSION}, with the ID in bits [7:4] and the version in bits [3:0] (0xA3 by default). Writes to it change nothing.
- R5: Address 0x02 is a read/write byte that resets to RES_INIT (0x07). Its bits [2:0] are the register-side resolution code (legal codes 0, 1, 4, 5, 6 and 7).
- R6: Address 0x03 is a read/write byte that resets to 0x00. Bit 7 is ownership (1 = registers control the outputs) and bit 0 is power (1 = active).
- R7: While bit 7 of 0x03 is 0, `resOut` equals `strapRes` and `standby` equals the inverse of `strapActive`.
- R8: While bit 7 of 0x03 is 1, `resOut` equals bits [2:0] of 0x02, `standby` equals the inverse of bit 0 of 0x03, and the strap inputs have no effect.
- R9: If chip select goes high in mid-frame, the frame is aborted: no register is written and `sdaOe` falls within four clocks. The next frame starts again from bit one.
- R10: Writes to addresses 0x04 to 0x3F change no register, and reads of those addresses return 0x00.
- R11: If chip select rises in the same clock as the sixteenth rising edge of a write, the write is dropped.
- R12: While `rstN` is low, every register returns to its reset value and `sdaOe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, used to oversample the link |
| rstN | input | 1 | Asynchronous active-low reset |
| csn | input | 1 | Active-low chip select from the host |
| sclk | input | 1 | Serial clock; idles low |
| sdaIn | input | 1 | Data line as seen from the pad |
| sdaOut | output | 1 | Value the slave drives on the data line |
| sdaOe | output | 1 | Drive enable for the data line pad |
| strapRes | input | 3 | Resolution code from strap pins |
| strapActive | input | 1 | Power state from strap pin (1 = active) |
| resOut | output | 3 | Effective resolution code |
| standby | output | 1 | Effective standby state (1 = standby) |

## Verification
The commit of a write and the end of the frame can fall in the same clock. The commit is made on the last rising clock edge, and the frame ends when chip select goes high. To provoke this, the bench raises chip select on the same block-clock edge as the sixteenth serial clock rise, so both changes pass through the synchronizer side by side. The write must then be lost, which a following read of the scratch byte shows: it still holds its old value. The bench also aborts frames at bit ten, once in write direction and once in read direction, and checks that the drive enable falls and that no register moved.

// File: rtl/tw_reg_pkg.sv
package tw_reg_pkg;
  localparam int ADDR_W     = 6;
  localparam int DATA_W     = 8;
  localparam int RES_W      = 3;
  localparam int FRAME_BITS = ADDR_W + 2 + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  // bit positions inside a frame (index = number of rising edges already seen)
  localparam int DIR_IDX    = ADDR_W;
  localparam int GAP_IDX    = ADDR_W + 1;
  localparam int DATA_IDX   = ADDR_W + 2;
  localparam int LAST_IDX   = FRAME_BITS - 1;
  // register map
  localparam logic [ADDR_W-1:0] ADDR_SCRATCH = 6'h00;
  localparam logic [ADDR_W-1:0] ADDR_ID      = 6'h01;
  localparam logic [ADDR_W-1:0] ADDR_RES     = 6'h02;
  localparam logic [ADDR_W-1:0] ADDR_CTL     = 6'h03;
  localparam int OWN_BIT = 7;
  localparam int PWR_BIT = 0;

  typedef struct packed {
    logic shiftIn;   // capture one received bit
    logic commitWr;  // last bit of a write frame arrives now
    logic loadRd;    // load read byte into output shifter
    logic shiftOut;  // advance output shifter
  } strobe_t;
endpackage

// File: rtl/tw_reg_ctrl.sv
module tw_reg_ctrl
  import tw_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             csn,
  input  logic             sdaIn,
  output strobe_t          strb,
  output logic             sdaSync,
  output logic             csnSync,
  output logic [CNT_W-1:0] bitCnt,
  output logic             isRead,
  output logic             sdaOe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclkSr, csnSr, sdaSr;
  logic sclkDly, sclkSync, rise, fall, inFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSr  <= '0;
      csnSr   <= '1;
      sdaSr   <= '0;
      sclkDly <= 1'b0;
    end else begin
      sclkSr  <= {sclkSr[TOP-1:0], sclk};
      csnSr   <= {csnSr[TOP-1:0], csn};
      sdaSr   <= {sdaSr[TOP-1:0], sdaIn};
      sclkDly <= sclkSr[TOP];
    end
  end

  assign sclkSync = sclkSr[TOP];
  assign csnSync  = csnSr[TOP];
  assign sdaSync  = sdaSr[TOP];
  assign inFrame  = !csnSync;
  assign rise     = inFrame && sclkSync && !sclkDly;
  assign fall     = inFrame && !sclkSync && sclkDly;

  always_comb begin
    strb          = '0;
    strb.shiftIn  = rise && (bitCnt < CNT_W'(FRAME_BITS)) && (bitCnt != CNT_W'(GAP_IDX));
    strb.commitWr = rise && (bitCnt == CNT_W'(LAST_IDX)) && !isRead;
    strb.loadRd   = fall && isRead && (bitCnt == CNT_W'(DATA_IDX));
    strb.shiftOut = fall && isRead && (bitCnt > CNT_W'(DATA_IDX))
                    && (bitCnt < CNT_W'(FRAME_BITS));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      isRead <= 1'b0;
      sdaOe  <= 1'b0;
    end else if (!inFrame) begin
      bitCnt <= '0;
      isRead <= 1'b0;
      sdaOe  <= 1'b0;
    end else begin
      if (rise && bitCnt < CNT_W'(FRAME_BITS)) begin
        bitCnt <= bitCnt + 1'b1;
        if (bitCnt == CNT_W'(DIR_IDX)) isRead <= sdaSync;
      end
      if (strb.loadRd) sdaOe <= 1'b1;
      else if (fall && bitCnt == CNT_W'(FRAME_BITS)) sdaOe <= 1'b0;
    end
  end
endmodule

// File: rtl/tw_reg_dpath.sv
module tw_reg_dpath
  import tw_reg_pkg::*;
#(
  parameter logic [3:0]        CHIP_ID  = 4'hA,
  parameter logic [3:0]        VERSION  = 4'h3,
  parameter logic [DATA_W-1:0] RES_INIT = 8'h07
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              sdaSync,
  input  logic [RES_W-1:0]  strapRes,
  input  logic              strapActive,
  output logic              sdaOut,
  output logic [RES_W-1:0]  resOut,
  output logic              standby,
  output logic [DATA_W-1:0] scratchQ,
  output logic [DATA_W-1:0] resQ,
  output logic [DATA_W-1:0] ctlQ,
  output logic [ADDR_W-1:0] wrAddr
);
  localparam int SR_W = FRAME_BITS - 2;  // pad bit is never stored, last bit taken live
  localparam logic [DATA_W-1:0] ID_BYTE = {CHIP_ID, VERSION};

  logic [SR_W-1:0]   inSr;
  logic [SR_W:0]     frame;
  logic [DATA_W-1:0] wrData, rdVal, outSr;
  logic [ADDR_W-1:0] rdAddr;
  logic              wrOk;

  assign frame  = {inSr, sdaSync};
  assign wrAddr = frame[SR_W -: ADDR_W];
  assign wrData = frame[DATA_W-1:0];
  assign wrOk   = strb.commitWr && !frame[DATA_W];  // direction bit must say write
  assign rdAddr = inSr[ADDR_W:1];

  always_comb begin
    unique case (rdAddr)
      ADDR_SCRATCH: rdVal = scratchQ;
      ADDR_ID:      rdVal = ID_BYTE;
      ADDR_RES:     rdVal = resQ;
      ADDR_CTL:     rdVal = ctlQ;
      default:      rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inSr     <= '0;
      outSr    <= '0;
      scratchQ <= '0;
      resQ     <= RES_INIT;
      ctlQ     <= '0;
    end else begin
      if (strb.shiftIn) inSr <= {inSr[SR_W-2:0], sdaSync};
      if (strb.loadRd) outSr <= rdVal;
      else if (strb.shiftOut) outSr <= {outSr[DATA_W-2:0], 1'b0};
      if (wrOk) begin
        case (wrAddr)
          ADDR_SCRATCH: scratchQ <= wrData;
          ADDR_RES:     resQ     <= wrData;
          ADDR_CTL:     ctlQ     <= wrData;
          default:      ;
        endcase
      end
    end
  end

  assign sdaOut  = outSr[DATA_W-1];
  assign resOut  = ctlQ[OWN_BIT] ? resQ[RES_W-1:0] : strapRes;
  assign standby = ctlQ[OWN_BIT] ? !ctlQ[PWR_BIT] : !strapActive;
endmodule

// File: rtl/tw_reg_slave.sv
module tw_reg_slave
  import tw_reg_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [3:0]        CHIP_ID     = 4'hA,
  parameter logic [3:0]        VERSION     = 4'h3,
  parameter logic [DATA_W-1:0] RES_INIT    = 8'h07
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csn,
  input  logic             sclk,
  input  logic             sdaIn,
  output logic             sdaOut,
  output logic             sdaOe,
  input  logic [RES_W-1:0] strapRes,
  input  logic             strapActive,
  output logic [RES_W-1:0] resOut,
  output logic             standby
);
  strobe_t           strb;
  logic              sdaSync, csnSync, isRead;
  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] scratchQ, resQ, ctlQ;
  logic [ADDR_W-1:0] wrAddr;

  tw_reg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csn(csn), .sdaIn(sdaIn),
    .strb(strb), .sdaSync(sdaSync), .csnSync(csnSync), .bitCnt(bitCnt),
    .isRead(isRead), .sdaOe(sdaOe)
  );

  tw_reg_dpath #(.CHIP_ID(CHIP_ID), .VERSION(VERSION), .RES_INIT(RES_INIT)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .sdaSync(sdaSync),
    .strapRes(strapRes), .strapActive(strapActive), .sdaOut(sdaOut),
    .resOut(resOut), .standby(standby), .scratchQ(scratchQ), .resQ(resQ),
    .ctlQ(ctlQ), .wrAddr(wrAddr)
  );
endmodule

// File: rtl/tw_reg_checker.sv
module tw_reg_checker
  import tw_reg_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              csnSync,
  input logic              sdaOe,
  input logic              isRead,
  input logic [CNT_W-1:0]  bitCnt,
  input strobe_t           strb,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [DATA_W-1:0] scratchQ,
  input logic [DATA_W-1:0] resQ,
  input logic [DATA_W-1:0] ctlQ
);
  assert_release_on_abort_R9: assert property (@(posedge clk) disable iff (!rstN)
    csnSync |=> !sdaOe);

  assert_drive_only_read_R2: assert property (@(posedge clk) disable iff (!rstN)
    sdaOe |-> isRead);

  assert_drive_after_turnaround_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> (bitCnt == CNT_W'(DATA_IDX)));

  assert_regs_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commitWr |=> ($stable(scratchQ) && $stable(resQ) && $stable(ctlQ)));

  assert_unmapped_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strb.commitWr && wrAddr > ADDR_CTL) |=> ($stable(scratchQ) && $stable(resQ) && $stable(ctlQ)));
endmodule

bind tw_reg_slave tw_reg_checker uChk (
  .clk(clk), .rstN(rstN), .csnSync(csnSync), .sdaOe(sdaOe), .isRead(isRead),
  .bitCnt(bitCnt), .strb(strb), .wrAddr(wrAddr), .scratchQ(scratchQ),
  .resQ(resQ), .ctlQ(ctlQ)
);

// File: tb/test_tw_reg_slave.sv
module test_tw_reg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 4;  // block clocks per serial clock phase

  logic clk = 1'b0, rstN = 1'b0, csn = 1'b1, sclk = 1'b0, sdaIn = 1'b0;
  logic sdaOut, sdaOe, strapActive = 1'b0, standby;
  logic [2:0] strapRes = 3'd6, resOut;
  int errs = 0, total = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tw_reg_slave i_tw_reg_slave (
    .clk(clk), .rstN(rstN), .csn(csn), .sclk(sclk), .sdaIn(sdaIn),
    .sdaOut(sdaOut), .sdaOe(sdaOe), .strapRes(strapRes),
    .strapActive(strapActive), .resOut(resOut), .standby(standby)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, total);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic b);
    sdaIn = b; wt(HALF); sclk = 1'b1; wt(HALF); sclk = 1'b0;
  endtask

  task automatic writeReg(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); csn = 1'b0; wt(HALF);
    for (int i = 5; i >= 0; i--) sendBit(a[i]);
    sendBit(1'b0);
    sendBit(1'b1);  // pad bit, deliberately 1
    for (int i = 7; i >= 0; i--) sendBit(d[i]);
    wt(HALF); csn = 1'b1; wt(2*HALF);
  endtask

  task automatic readReg(input logic [5:0] a, output logic [7:0] d);
    logic oeAll;
    oeAll = 1'b1;
    @(negedge clk); csn = 1'b0; wt(HALF);
    for (int i = 5; i >= 0; i--) sendBit(a[i]);
    sendBit(1'b1);
    sdaIn = 1'b0; wt(HALF);
    chk("R2 line released in turnaround", sdaOe, 0);
    sclk = 1'b1; wt(HALF); sclk = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wt(HALF);
      oeAll &= sdaOe;
      d[i] = sdaOut;
      sclk = 1'b1; wt(HALF); sclk = 1'b0;
    end
    chk("R2 driven through all data bits", oeAll, 1);
    wt(HALF);
    chk("R2 released after last bit", sdaOe, 0);
    csn = 1'b1; wt(2*HALF);
  endtask

  task automatic expectReg(input string tag, input logic [5:0] a, input logic [7:0] e);
    logic [7:0] d;
    readReg(a, d);
    chk(tag, d, e);
  endtask

  task automatic t_reset();
    chk("R12 oe low after reset", sdaOe, 0);
    chk("R7 strap resolution at reset", resOut, 3'd6);
    chk("R7 strap standby at reset", standby, 1);
    expectReg("R3 scratch reset value", 6'h00, 8'h00);
    expectReg("R5 resolution reset value", 6'h02, 8'h07);
    expectReg("R6 control reset value", 6'h03, 8'h00);
  endtask

  task automatic t_scratch();
    writeReg(6'h00, 8'h55);
    expectReg("R3 scratch 0x55 readback", 6'h00, 8'h55);
    writeReg(6'h00, 8'hA6);
    expectReg("R1 scratch 0xA6 bit order", 6'h00, 8'hA6);
  endtask

  task automatic t_identity();
    expectReg("R4 identity value", 6'h01, 8'hA3);
    writeReg(6'h01, 8'h00);
    expectReg("R4 identity after write", 6'h01, 8'hA3);
  endtask

  task automatic t_unmapped();
    writeReg(6'h04, 8'hFF);
    writeReg(6'h3F, 8'h99);
    writeReg(6'h06, 8'h12);
    expectReg("R10 read 0x3F", 6'h3F, 8'h00);
    expectReg("R10 read 0x04", 6'h04, 8'h00);
    expectReg("R10 scratch untouched", 6'h00, 8'hA6);
    expectReg("R10 resolution untouched", 6'h02, 8'h07);
    expectReg("R10 control untouched", 6'h03, 8'h00);
  endtask

  task automatic t_ownership();
    strapRes = 3'd5; strapActive = 1'b1; wt(2);
    chk("R7 strap resolution follows", resOut, 3'd5);
    chk("R7 strap active", standby, 0);
    writeReg(6'h02, 8'h04);
    writeReg(6'h03, 8'h81);
    expectReg("R5 resolution readback", 6'h02, 8'h04);
    expectReg("R6 control readback", 6'h03, 8'h81);
    chk("R8 register resolution", resOut, 3'd4);
    chk("R8 register active", standby, 0);
    strapRes = 3'd1; strapActive = 1'b0; wt(2);
    chk("R8 strap resolution ignored", resOut, 3'd4);
    chk("R8 strap power ignored", standby, 0);
    writeReg(6'h03, 8'h80);
    chk("R8 register standby", standby, 1);
    writeReg(6'h03, 8'h01);
    chk("R7 back to strap resolution", resOut, 3'd1);
    chk("R7 back to strap standby", standby, 1);
  endtask

  task automatic t_abort();
    logic [15:0] f;
    f = {6'h00, 1'b0, 1'b0, 8'h3C};
    @(negedge clk); csn = 1'b0; wt(HALF);
    for (int i = 15; i >= 6; i--) sendBit(f[i]);
    csn = 1'b1; wt(2*HALF);
    expectReg("R9 aborted write leaves scratch", 6'h00, 8'hA6);
    f = {6'h00, 1'b1, 1'b0, 8'h00};
    @(negedge clk); csn = 1'b0; wt(HALF);
    for (int i = 15; i >= 6; i--) sendBit(f[i]);
    wt(HALF);
    chk("R9 read in progress drives", sdaOe, 1);
    csn = 1'b1; wt(HALF);
    chk("R9 abort releases line", sdaOe, 0);
    wt(HALF);
    expectReg("R9 next frame restarts", 6'h01, 8'hA3);
  endtask

  task automatic t_sameCycle();
    logic [15:0] f;
    f = {6'h00, 1'b0, 1'b0, 8'h5A};
    @(negedge clk); csn = 1'b0; wt(HALF);
    for (int i = 15; i >= 1; i--) sendBit(f[i]);
    sdaIn = f[0]; wt(HALF);
    sclk = 1'b1; csn = 1'b1;
    wt(HALF); sclk = 1'b0; wt(2*HALF);
    expectReg("R11 write dropped on same-cycle deselect", 6'h00, 8'hA6);
  endtask

  task automatic t_resetMid();
    writeReg(6'h00, 8'h3C);
    writeReg(6'h02, 8'h05);
    writeReg(6'h03, 8'h81);
    @(negedge clk); rstN = 1'b0; wt(3);
    chk("R12 oe low in reset", sdaOe, 0);
    chk("R12 ownership cleared in reset", resOut, strapRes);
    rstN = 1'b1; wt(3);
    expectReg("R12 scratch cleared", 6'h00, 8'h00);
    expectReg("R12 resolution restored", 6'h02, 8'h07);
    expectReg("R12 control cleared", 6'h03, 8'h00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; total++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    wt(4); rstN = 1'b1; wt(4);
    t_reset();
    t_scratch();
    t_identity();
    t_unmapped();
    t_ownership();
    t_abort();
    t_sameCycle();
    t_resetMid();
    summary();
    $finish;
  end
endmodule